// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a parallel I/O peripheral that a processor reaches over an 8-bit bus. It has three 8-bit ports, A, B and C. Port C is split into a high nibble and a low nibble, and each nibble has its own direction. Software writes a control word to choose, group by group, whether the pins are driven or sampled. It then reads or writes the ports through the same bus. Only plain input/output operation is supported. A control word that asks for any other mode is dropped.

The bus side uses an active-low chip select, active-low read and write strobes, and a 2-bit address:

| Address | Selects |
|---|---|
| 0 | port A |
| 1 | port B |
| 2 | port C |
| 3 | control register |

Bus timing:
- A write happens at every rising clock edge where chip select and write are both low.
- Read data is combinational from the current state.
- Pin inputs pass through one sampling register before they can be read.

Top module: `par_io_port`

## Requirements
- R1: After reset, every port output-enable is low and every output latch is zero. Reading address 3 returns 8'h9B, which is all four groups set to input.
- R2: A valid control word has bit 7 = 1 and bits 6, 5 and 2 all zero. It sets the direction of four groups, where 1 means input and 0 means output:
  - bit 4: port A
  - bit 3: port C high nibble
  - bit 1: port B
  - bit 0: port C low nibble

  Each group's output-enable bits are all high when that group is an output and all low when it is an input. The new enables appear from the clock edge that takes the write.
- R3: A write to address 3 is ignored when bit 7 = 0, or when bit 7 = 1 and any of bits 6, 5 or 2 is set. Directions and latches keep their values.
- R4: A valid control-word write clears the output latches of A, B and C to zero.
- R5: A write with chip select and write low loads the latch of the addressed port from the data bus at the clock edge:
  - address 0 loads port A
  - address 1 loads port B
  - address 2 loads both nibbles of port C

  The port's output pins show the new value from that edge onward.
- R6: Reading a group set as input returns the pin value captured at the previous rising edge.
- R7: Reading a group set as output returns its latch. Port C is assembled nibble by nibble, each nibble according to its own direction.
- R8: The bus output-enable is high only while chip select and read are both low. With chip select high, a write strobe changes nothing.
- R9: A read of address 3 returns the current control word. That word is bit 7 = 1, bits 6, 5 and 2 = 0, and the direction bits placed as in R2.
- R10: When read and write strobes are low together on an output port, the bus shows the old latch before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Write data from processor |
| dataOut | output | 8 | Read data to processor |
| dataOe | output | 1 | Drive enable for read data |
| portAIn | input | 8 | Port A pins, sampled |
| portAOut | output | 8 | Port A latch toward pins |
| portAOe | output | 8 | Port A pin drive enables |
| portBIn | input | 8 | Port B pins, sampled |
| portBOut | output | 8 | Port B latch toward pins |
| portBOe | output | 8 | Port B pin drive enables |
| portCIn | input | 8 | Port C pins, sampled |
| portCOut | output | 8 | Port C latch toward pins |
| portCOe | output | 8 | Port C drive enables, per nibble |

## Verification
A read of a port and a write to that same port can land in one cycle. The bench provokes this by holding both strobes low on port A while it is an output. It judges the result by sampling the bus before the edge, where the old latch is expected, and after the edge, where the new data is expected. A second overlap is a direction change and a latch clear arriving in the same control write. That case is judged by the enables and the zeroed pins in the following cycle.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic wrCtl;
    logic rdEn;
    logic [ADDR_W-1:0] sel;
  } ioStrobe_t;
endpackage

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
  import par_io_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic csN,
  input  logic rdN,
  input  logic wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output ioStrobe_t strb
);
  logic wrActive;
  logic modeOk;

  assign wrActive = !csN && !wrN;
  // Only plain I/O: flag bit set, strobed/bidirectional bits clear.
  assign modeOk = dataIn[7] && (dataIn[6:5] == 2'b00) && !dataIn[2];

  always_comb begin
    strb.wrA   = wrActive && (addr == 2'd0);
    strb.wrB   = wrActive && (addr == 2'd1);
    strb.wrC   = wrActive && (addr == 2'd2);
    strb.wrCtl = wrActive && (addr == 2'd3) && modeOk;
    strb.rdEn  = !csN && !rdN;
    strb.sel   = addr;
  end

  assert_cs_gate_R8: assert property (@(posedge clk) disable iff (rst)
    csN |-> !(strb.wrA || strb.wrB || strb.wrC || strb.wrCtl || strb.rdEn));

  assert_one_write_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrA, strb.wrB, strb.wrC, strb.wrCtl}));
endmodule

// File: rtl/par_io_datapath.sv
module par_io_datapath
  import par_io_pkg::*;
#(
  parameter int PORT_W = DATA_W
) (
  input  logic clk,
  input  logic rst,
  input  ioStrobe_t strb,
  input  logic [PORT_W-1:0] dataIn,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] latA,
  output logic [PORT_W-1:0] latB,
  output logic [PORT_W-1:0] latC,
  output logic [PORT_W-1:0] oeA,
  output logic [PORT_W-1:0] oeB,
  output logic [PORT_W-1:0] oeC
);
  localparam int HALF = PORT_W / 2;

  logic dirA, dirB, dirCu, dirCl;
  logic [PORT_W-1:0] pinA, pinB, pinC;
  logic [PORT_W-1:0] readC;
  logic [PORT_W-1:0] ctlWord;
  logic [1:0] dirC;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirA  <= 1'b1;
      dirB  <= 1'b1;
      dirCu <= 1'b1;
      dirCl <= 1'b1;
      latA  <= '0;
      latB  <= '0;
      latC  <= '0;
      pinA  <= '0;
      pinB  <= '0;
      pinC  <= '0;
    end else begin
      pinA <= portAIn;
      pinB <= portBIn;
      pinC <= portCIn;
      if (strb.wrCtl) begin
        dirA  <= dataIn[4];
        dirCu <= dataIn[3];
        dirB  <= dataIn[1];
        dirCl <= dataIn[0];
        latA  <= '0;
        latB  <= '0;
        latC  <= '0;
      end else begin
        if (strb.wrA) latA <= dataIn;
        if (strb.wrB) latB <= dataIn;
        if (strb.wrC) latC <= dataIn;
      end
    end
  end

  assign dirC = {dirCu, dirCl};

  genvar n;
  generate
    for (n = 0; n < 2; n++) begin : gNib
      assign readC[n*HALF +: HALF] = dirC[n] ? pinC[n*HALF +: HALF] : latC[n*HALF +: HALF];
      assign oeC[n*HALF +: HALF]   = {HALF{!dirC[n]}};
    end
  endgenerate

  assign oeA = {PORT_W{!dirA}};
  assign oeB = {PORT_W{!dirB}};

  always_comb begin
    ctlWord    = '0;
    ctlWord[7] = 1'b1;
    ctlWord[4] = dirA;
    ctlWord[3] = dirCu;
    ctlWord[1] = dirB;
    ctlWord[0] = dirCl;
  end

  always_comb begin
    case (strb.sel)
      2'd0:    rdData = dirA ? pinA : latA;
      2'd1:    rdData = dirB ? pinB : latB;
      2'd2:    rdData = readC;
      default: rdData = ctlWord;
    endcase
  end

  assert_hold_latA_R5: assert property (@(posedge clk) disable iff (rst)
    (!strb.wrA && !strb.wrCtl) |=> $stable(latA));

  assert_clear_latches_R4: assert property (@(posedge clk) disable iff (rst)
    strb.wrCtl |=> (latA == '0) && (latB == '0) && (latC == '0));
endmodule

// File: rtl/par_io_port.sv
module par_io_port
  import par_io_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic csN,
  input  logic rdN,
  input  logic wrN,
  input  logic [1:0] addr,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic dataOe,
  input  logic [7:0] portAIn,
  output logic [7:0] portAOut,
  output logic [7:0] portAOe,
  input  logic [7:0] portBIn,
  output logic [7:0] portBOut,
  output logic [7:0] portBOe,
  input  logic [7:0] portCIn,
  output logic [7:0] portCOut,
  output logic [7:0] portCOe
);
  ioStrobe_t strb;

  par_io_ctrl ctrl_i (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .strb(strb)
  );

  par_io_datapath #(.PORT_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(dataIn),
    .portAIn(portAIn), .portBIn(portBIn), .portCIn(portCIn),
    .rdData(dataOut), .latA(portAOut), .latB(portBOut), .latC(portCOut),
    .oeA(portAOe), .oeB(portBOe), .oeC(portCOe)
  );

  assign dataOe = strb.rdEn;

  assert_bus_oe_R8: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> (!csN && !rdN));

  assert_bad_ctl_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!csN && !wrN && addr == 2'd3 && !dataIn[7])
    |=> $stable(portAOe) && $stable(portBOe) && $stable(portCOe));

  assert_group_oe_R2: assert property (@(posedge clk) disable iff (rst)
    (portAOe == 8'h00 || portAOe == 8'hFF) && (portBOe == 8'h00 || portBOe == 8'hFF));
endmodule

// File: tb/par_io_port_tb_top.sv
`timescale 1ns/1ps
module par_io_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic dataOe;
  logic [7:0] portAIn = 8'h00, portBIn = 8'h00, portCIn = 8'h00;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int sel;
    logic [7:0] exp;
  } item_t;
  item_t q[$];
  event sampleEv;

  always #2.5 clk = ~clk;

  par_io_port dut_i (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return dataOut;
      1: return {7'd0, dataOe};
      2: return portAOut;
      3: return portAOe;
      4: return portBOut;
      5: return portBOe;
      6: return portCOut;
      default: return portCOe;
    endcase
  endfunction

  // Monitor: pops expectations and compares against the live outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(string tag, int sel, logic [7:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> sampleEv;
    #0.01;
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d, logic cs = 1'b0);
    @(negedge clk);
    csN = cs; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(string tag, logic [1:0] a, logic [7:0] exp);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #1;
    chk(tag, 0, exp);
    chk({tag, " oe"}, 1, 8'h01);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 portAOe", 3, 8'h00);
    chk("R1 portBOe", 5, 8'h00);
    chk("R1 portCOe", 7, 8'h00);
    chk("R1 portAOut", 2, 8'h00);
    chk("R8 idle dataOe", 1, 8'h00);
    busRead("R1 R9 reset control word", 2'd3, 8'h9B);

    // R2 all groups to output
    busWrite(2'd3, 8'h80);
    #1;
    chk("R2 portAOe", 3, 8'hFF);
    chk("R2 portBOe", 5, 8'hFF);
    chk("R2 portCOe", 7, 8'hFF);
    busRead("R9 control readback", 2'd3, 8'h80);

    // R5 latch writes
    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h7E);
    #1;
    chk("R5 portAOut", 2, 8'h5A);
    chk("R5 portBOut", 4, 8'hC3);
    chk("R5 portCOut", 6, 8'h7E);
    busRead("R7 read output A", 2'd0, 8'h5A);
    busRead("R7 read output C", 2'd2, 8'h7E);

    // R3 bad control words
    busWrite(2'd3, 8'h0B);
    busWrite(2'd3, 8'hC0);
    busWrite(2'd3, 8'h84);
    #1;
    chk("R3 portAOe kept", 3, 8'hFF);
    chk("R3 portCOe kept", 7, 8'hFF);
    chk("R3 portAOut kept", 2, 8'h5A);
    chk("R3 portBOut kept", 4, 8'hC3);

    // R8 chip select high blocks writes
    busWrite(2'd0, 8'h99, 1'b1);
    busWrite(2'd3, 8'h9B, 1'b1);
    #1;
    chk("R8 cs high no write", 2, 8'h5A);
    chk("R8 cs high no ctl", 3, 8'hFF);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b0;
    #1;
    chk("R8 rd without cs", 1, 8'h00);
    rdN = 1'b1;

    // R4 + R2: A in, C high out, C low in, B out
    busWrite(2'd3, 8'h91);
    #1;
    chk("R4 portAOut cleared", 2, 8'h00);
    chk("R4 portBOut cleared", 4, 8'h00);
    chk("R4 portCOut cleared", 6, 8'h00);
    chk("R2 portAOe input", 3, 8'h00);
    chk("R2 portBOe output", 5, 8'hFF);
    chk("R2 portCOe split", 7, 8'hF0);

    // R6 / R7 mixed reads
    portAIn = 8'h3C; portCIn = 8'hA5; portBIn = 8'h11;
    busWrite(2'd2, 8'h6B);
    busWrite(2'd1, 8'hE7);
    busRead("R6 read input A", 2'd0, 8'h3C);
    busRead("R7 R6 read split C", 2'd2, 8'h65);
    busRead("R7 read output B", 2'd1, 8'hE7);
    @(negedge clk);
    portAIn = 8'h81;
    busRead("R6 read new pins A", 2'd0, 8'h81);

    // R10 read and write in the same cycle on output A
    busWrite(2'd3, 8'h8B);
    busWrite(2'd0, 8'h11);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; addr = 2'd0; dataIn = 8'h22;
    #1;
    chk("R10 old before edge", 0, 8'h11);
    @(posedge clk);
    #1;
    chk("R10 new after edge", 0, 8'h22);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    #1;
    chk("R10 latch holds", 2, 8'h22);

    finished = 1'b1;
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule